// File: doc/BRIEF.md
# Per-Core Miss History Logger

This block records one core's stream of correct-path memory misses into a circular log in main memory, so that later lookups can replay the sequence. The core's commit logic presents each retiring instruction with a marked flag, which is set when the instruction was an off-chip load miss or a hit on a prefetched block. It also presents a kind bit and the block address. Only marked instructions are logged, so accesses on a mispredicted path never reach the log.

Logged entries are packed twelve to a 512-bit line in a staging register. A full line leaves as one write to the log region at a base address plus the line offset, and the line index wraps at the configured log size. Each logged entry also raises an index-update candidate on the cycle after it is accepted. The candidate carries the address and the entry's position in the log.

Each entry also holds a one-bit end-of-stream mark. The mark is set on the first off-chip miss that follows a run of one or more prefetch hits, which closes that run as a stream. When a full line cannot be written because an earlier line is still waiting at the memory port, the retire input is held off and no entry is lost.

Top module: `hist_logger`

## Requirements
- R1: After reset, `upd_valid` and `mem_wvalid` are low, `ret_ready` is high, and the first logged entry reports pointer 0.
- R2: A retire handshake (`ret_valid` and `ret_ready` high) with `ret_marked` low raises no update candidate, produces no write, and leaves the next pointer unchanged.
- R3: A retire handshake with `ret_marked` high raises `upd_valid` for the following cycle, with `upd_addr` equal to the retired address.
- R4: The pointer of successive logged entries increases by one and wraps from HIST_LINES*12-1 back to 0.
- R5: After every twelfth logged entry, one write is presented in the next cycle. Entry k (k = 0 is the oldest) sits at bits [33k+31:33k] as the address, with its end mark at bit 33k+32. Bits 511:396 are zero. Fewer than twelve entries never produce a write.
- R6: The write address of the n-th line is BASE_ADDR + 64*(n mod HIST_LINES).
- R7: An entry's end mark is 1 exactly when it is an off-chip miss (`ret_pfhit` = 0) and the previous logged entry was a prefetch hit (`ret_pfhit` = 1). Unmarked retires in between do not break the run.
- R8: While `mem_wvalid` is high and `mem_wready` is low, the write valid, address and data stay unchanged.
- R9: `ret_ready` goes low only while a write is pending and eleven entries are already staged. Entries presented during this stall are taken after the write drains, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | A retiring instruction is presented |
| ret_ready | output | 1 | Logger can take the retiring instruction |
| ret_marked | input | 1 | Instruction was an off-chip miss or a prefetched hit |
| ret_pfhit | input | 1 | 1 = prefetched hit, 0 = off-chip miss |
| ret_addr | input | 32 | Block address of the instruction |
| mem_wvalid | output | 1 | Line write request |
| mem_wready | input | 1 | Memory accepts the line write |
| mem_waddr | output | 40 | Byte address of the line in the log |
| mem_wdata | output | 512 | Packed line of twelve entries |
| upd_valid | output | 1 | Index-update candidate valid |
| upd_addr | output | 32 | Address of the candidate |
| upd_ptr | output | 6 | Log position of the candidate |

## Verification
The bench pushes the log past its end, because a pointer or line address that fails to wrap would write outside the log region and hand out positions that do not exist. It builds streams in which runs of prefetch hits are split by unmarked retires, because a design that counts unmarked traffic would clear or move the end mark. It holds the memory port busy until the staging line is one entry from full: a design that drops or takes the stalled entry early would lose an address or shift every later slot. Marked-off retires are checked for a stray candidate and for a pointer that advanced without an entry.

// File: rtl/hist_logger_pkg.sv
// Shared types for the miss history logger: one log entry is a block
// address plus an end-of-stream flag.
package hist_logger_pkg;
    localparam int BLK_W = 32;

    typedef struct packed {
        logic             eos;
        logic [BLK_W-1:0] blk;
    } hist_entry_t;

    localparam int ENTRY_W = $bits(hist_entry_t);
endpackage

// File: rtl/hist_eos_tracker.sv
// End-of-stream tracker. Remembers whether the last logged entry was a
// prefetch hit; a miss logged right after such a run is flagged as the
// stream end. Assumes append pulses only for entries that enter the log.
module hist_eos_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic append,
    input  logic is_pf_hit,
    output logic eos
);
    logic in_run;

    // Flag a miss that closes a run of prefetch hits.
    always_comb eos = in_run && !is_pf_hit;

    // Track whether the newest logged entry was a prefetch hit.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_run <= 1'b0;
        else if (append) in_run <= is_pf_hit;
    end
endmodule

// File: rtl/hist_stager.sv
// Line staging buffer. Collects EPL entries into slot registers and
// presents the packed line (with the arriving entry overlaid) so the
// caller can load it when the last slot fills. Spare upper bits are zero.
// Assumes append is never raised while the caller cannot take a full line.
module hist_stager #(
    parameter int EPL       = 12,
    parameter int LINE_BITS = 512,
    parameter int SLOT_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          append,
    input  hist_logger_pkg::hist_entry_t  entry,
    output logic [SLOT_W-1:0]             slot,
    output logic                          line_full,
    output logic [LINE_BITS-1:0]          line_data
);
    import hist_logger_pkg::*;

    localparam int                USED_BITS = EPL * ENTRY_W;
    localparam logic [SLOT_W-1:0] LAST      = SLOT_W'(EPL - 1);

    hist_entry_t ent [EPL];

    // Last slot taken completes the line.
    always_comb line_full = append && (slot == LAST);

    // Slot counter: next free position in the staging line.
    always_ff @(posedge clk) begin
        if (!rst_n)         slot <= '0;
        else if (line_full) slot <= '0;
        else if (append)    slot <= slot + 1'b1;
    end

    for (genvar k = 0; k < EPL; k++) begin : g_slot
        // Capture the arriving entry into its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                              ent[k] <= '0;
            else if (append && slot == SLOT_W'(k))   ent[k] <= entry;
        end
        // Pack the slot, taking the arriving entry directly when it lands here.
        assign line_data[k*ENTRY_W +: ENTRY_W] =
            (append && slot == SLOT_W'(k)) ? entry : ent[k];
    end

    if (LINE_BITS > USED_BITS) begin : g_spare
        assign line_data[LINE_BITS-1:USED_BITS] = '0;
    end
endmodule

// File: rtl/hist_line_writer.sv
// Line write holding register. Loads one packed line and its address and
// presents them on a valid/ready write port until accepted. Assumes load
// is only raised while no write is pending.
module hist_line_writer #(
    parameter int LINE_BITS  = 512,
    parameter int MEM_ADDR_W = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [MEM_ADDR_W-1:0] load_addr,
    input  logic [LINE_BITS-1:0]  load_data,
    output logic                  busy,
    output logic [MEM_ADDR_W-1:0] wr_addr,
    output logic [LINE_BITS-1:0]  wr_data,
    input  logic                  wr_ready
);
    // Hold the pending line until the memory port takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            wr_addr <= load_addr;
            wr_data <= load_data;
        end else if (busy && wr_ready) begin
            busy    <= 1'b0;
        end
    end
endmodule

// File: rtl/hist_logger.sv
// Per-core miss history logger top. Logs marked retires into a circular
// line-packed log, emits one index-update candidate per logged entry and
// stalls the retire input only when a full line cannot leave.
// Assumes the memory port keeps a request once it has seen it valid.
module hist_logger #(
    parameter int                    HIST_LINES = 4,
    parameter int                    EPL        = 12,
    parameter int                    LINE_BITS  = 512,
    parameter int                    MEM_ADDR_W = 40,
    parameter logic [MEM_ADDR_W-1:0] BASE_ADDR  = 40'h0010_0000,
    localparam int                   HIST_ENTRIES = HIST_LINES * EPL,
    localparam int                   PTR_W        = $clog2(HIST_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ret_valid,
    output logic                              ret_ready,
    input  logic                              ret_marked,
    input  logic                              ret_pfhit,
    input  logic [hist_logger_pkg::BLK_W-1:0] ret_addr,
    output logic                              mem_wvalid,
    input  logic                              mem_wready,
    output logic [MEM_ADDR_W-1:0]             mem_waddr,
    output logic [LINE_BITS-1:0]              mem_wdata,
    output logic                              upd_valid,
    output logic [hist_logger_pkg::BLK_W-1:0] upd_addr,
    output logic [PTR_W-1:0]                  upd_ptr
);
    import hist_logger_pkg::*;

    localparam int                    SLOT_W     = $clog2(EPL);
    localparam int                    LIDX_W     = (HIST_LINES > 1) ? $clog2(HIST_LINES) : 1;
    localparam int                    LINE_BYTES = LINE_BITS / 8;
    localparam logic [SLOT_W-1:0]     LAST_SLOT  = SLOT_W'(EPL - 1);
    localparam logic [LIDX_W-1:0]     LAST_LINE  = LIDX_W'(HIST_LINES - 1);

    logic                  append;
    logic                  eos;
    logic                  line_full;
    logic                  wr_busy;
    logic [SLOT_W-1:0]     slot;
    logic [LIDX_W-1:0]     lidx;
    logic [PTR_W-1:0]      cur_ptr;
    logic [MEM_ADDR_W-1:0] line_addr;
    logic [LINE_BITS-1:0]  line_data;
    hist_entry_t           new_entry;

    // Stall only when the last slot would fill while a line still waits.
    always_comb ret_ready = !(wr_busy && slot == LAST_SLOT);

    // An entry enters the log on a handshake with the marked flag set.
    always_comb append = ret_valid && ret_ready && ret_marked;

    // Form the entry and its log position and line address.
    always_comb begin
        new_entry.eos = eos;
        new_entry.blk = ret_addr;
        cur_ptr       = PTR_W'(lidx) * PTR_W'(EPL) + PTR_W'(slot);
        line_addr     = BASE_ADDR + MEM_ADDR_W'(lidx) * MEM_ADDR_W'(LINE_BYTES);
    end

    // Line index advances on every completed line and wraps at the log end.
    always_ff @(posedge clk) begin
        if (!rst_n)         lidx <= '0;
        else if (line_full) lidx <= (lidx == LAST_LINE) ? '0 : lidx + 1'b1;
    end

    // Register the index-update candidate for the accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_addr  <= '0;
            upd_ptr   <= '0;
        end else begin
            upd_valid <= append;
            if (append) begin
                upd_addr <= ret_addr;
                upd_ptr  <= cur_ptr;
            end
        end
    end

    hist_eos_tracker u_eos (
        .clk       (clk),
        .rst_n     (rst_n),
        .append    (append),
        .is_pf_hit (ret_pfhit),
        .eos       (eos)
    );

    hist_stager #(
        .EPL       (EPL),
        .LINE_BITS (LINE_BITS),
        .SLOT_W    (SLOT_W)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .append    (append),
        .entry     (new_entry),
        .slot      (slot),
        .line_full (line_full),
        .line_data (line_data)
    );

    hist_line_writer #(
        .LINE_BITS  (LINE_BITS),
        .MEM_ADDR_W (MEM_ADDR_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (line_full),
        .load_addr (line_addr),
        .load_data (line_data),
        .busy      (wr_busy),
        .wr_addr   (mem_waddr),
        .wr_data   (mem_wdata),
        .wr_ready  (mem_wready)
    );

    always_comb mem_wvalid = wr_busy;
endmodule

// File: rtl/hist_logger_chk.sv
// Property checker for the miss history logger, attached by bind.
// Relates the retire handshake, the candidate port and the write port.
module hist_logger_chk #(
    parameter int LINE_BITS    = 512,
    parameter int MEM_ADDR_W   = 40,
    parameter int HIST_ENTRIES = 48,
    parameter int PTR_W        = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ret_valid,
    input logic                  ret_ready,
    input logic                  ret_marked,
    input logic                  mem_wvalid,
    input logic                  mem_wready,
    input logic [MEM_ADDR_W-1:0] mem_waddr,
    input logic [LINE_BITS-1:0]  mem_wdata,
    input logic                  upd_valid,
    input logic [PTR_W-1:0]      upd_ptr
);
    // R3
    upd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_ready && ret_marked) |=> upd_valid);

    // R2
    no_stray_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_valid && ret_ready && ret_marked) |=> !upd_valid);

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=>
            (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    // R9
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_ready |-> mem_wvalid);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && $past(upd_valid)) |->
            (upd_ptr == (($past(upd_ptr) == PTR_W'(HIST_ENTRIES - 1)) ?
                         '0 : $past(upd_ptr) + 1'b1)));
endmodule

bind hist_logger hist_logger_chk #(
    .LINE_BITS    (LINE_BITS),
    .MEM_ADDR_W   (MEM_ADDR_W),
    .HIST_ENTRIES (HIST_ENTRIES),
    .PTR_W        (PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_valid  (ret_valid),
    .ret_ready  (ret_ready),
    .ret_marked (ret_marked),
    .mem_wvalid (mem_wvalid),
    .mem_wready (mem_wready),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .upd_valid  (upd_valid),
    .upd_ptr    (upd_ptr)
);

// File: tb/hist_logger_bench.sv
// Directed bench for the miss history logger: one task per scenario.
module hist_logger_bench;
    localparam int          NLINES  = 4;
    localparam int          EPL     = 12;
    localparam int          ENTRIES = NLINES * EPL;
    localparam logic [39:0] BASE    = 40'h0010_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ret_valid = 1'b0;
    logic         ret_ready;
    logic         ret_marked = 1'b0;
    logic         ret_pfhit = 1'b0;
    logic [31:0]  ret_addr = '0;
    logic         mem_wvalid;
    logic         mem_wready = 1'b1;
    logic [39:0]  mem_waddr;
    logic [511:0] mem_wdata;
    logic         upd_valid;
    logic [31:0]  upd_addr;
    logic [5:0]   upd_ptr;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_ptr = 0;
    int n_app   = 0;
    int n_lines = 0;
    bit in_run  = 0;
    logic [32:0] exp_q[$];

    always #4 clk = ~clk;

    hist_logger u_hist_logger (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_marked(ret_marked), .ret_pfhit(ret_pfhit), .ret_addr(ret_addr),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .upd_valid(upd_valid), .upd_addr(upd_addr),
        .upd_ptr(upd_ptr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Write monitor: samples just after the falling edge, away from the clock.
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_wvalid && mem_wready) begin
            if (exp_q.size() < EPL) begin
                check(0, "R5", "write with partial line", exp_q.size(), EPL);
            end else begin
                logic [39:0] ea;
                ea = BASE + 40'((n_lines % NLINES) * 64);
                check(mem_waddr == ea, "R6", "line address", mem_waddr, ea);
                for (int k = 0; k < EPL; k++) begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check(mem_wdata[k*33 +: 32] == e[31:0], "R5", "slot address",
                          mem_wdata[k*33 +: 32], e[31:0]);
                    check(mem_wdata[k*33+32] == e[32], "R7", "end mark",
                          mem_wdata[k*33+32], e[32]);
                end
                check(mem_wdata[511:396] == '0, "R5", "spare bits", 1, 0);
                n_lines++;
            end
        end
    end

    // Completes an already-driven marked retire and checks its candidate.
    task automatic finish_append(input logic [31:0] a, input logic hit);
        while (!ret_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        exp_q.push_back({(!hit && in_run), a});
        in_run = hit;
        n_app++;
        ret_valid = 1'b0;
        check(upd_valid == 1'b1, "R3", "candidate valid", upd_valid, 1);
        check(upd_addr == a, "R3", "candidate address", upd_addr, a);
        check(upd_ptr == 6'(exp_ptr), "R4", "candidate pointer", upd_ptr, exp_ptr);
        exp_ptr = (exp_ptr + 1) % ENTRIES;
    endtask

    task automatic append(input logic [31:0] a, input logic hit);
        @(negedge clk);
        ret_valid = 1'b1; ret_marked = 1'b1; ret_pfhit = hit; ret_addr = a;
        finish_append(a, hit);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(upd_valid == 0, "R1", "upd_valid after reset", upd_valid, 0);
        check(mem_wvalid == 0, "R1", "mem_wvalid after reset", mem_wvalid, 0);
        check(ret_ready == 1, "R1", "ret_ready after reset", ret_ready, 1);
        append(32'hA000_0001, 1'b0);  // R1: first pointer checked as 0
    endtask

    task automatic t_ignore();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ret_valid = 1'b1; ret_marked = 1'b0; ret_addr = 32'hDEAD_0000 + i;
            @(negedge clk);
            ret_valid = 1'b0;
            check(upd_valid == 0, "R2", "unmarked raised candidate", upd_valid, 0);
            check(mem_wvalid == 0, "R2", "unmarked raised write", mem_wvalid, 0);
        end
        append(32'hA000_0002, 1'b0);  // R2: pointer must not have moved
    endtask

    task automatic t_endmark();
        append(32'hB000_0001, 1'b1);
        append(32'hB000_0002, 1'b1);
        append(32'hB000_0003, 1'b0);  // R7: closes run
        append(32'hB000_0004, 1'b0);
        append(32'hB000_0005, 1'b1);
        @(negedge clk);
        ret_valid = 1'b1; ret_marked = 1'b0; ret_addr = 32'hB0FF_0000;
        @(negedge clk);
        ret_valid = 1'b0;
        append(32'hB000_0006, 1'b0);  // R7: run survives unmarked retire
        while (n_app % EPL != 0) append(32'hB100_0000 + n_app, n_app[0]);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5", "lines written", exp_q.size(), 0);
    endtask

    task automatic t_backpressure();
        logic [39:0]  held_a;
        logic [511:0] held_d;
        @(negedge clk);
        mem_wready = 1'b0;
        for (int i = EPL - (n_app % EPL); i > 0; i--) append(32'hC000_0000 + i, 1'b0);
        for (int i = 0; i < EPL - 1; i++) append(32'hC100_0000 + i, i[0]);
        check(mem_wvalid == 1, "R8", "write pending", mem_wvalid, 1);
        held_a = mem_waddr;
        held_d = mem_wdata;
        @(negedge clk);
        ret_valid = 1'b1; ret_marked = 1'b1; ret_pfhit = 1'b0; ret_addr = 32'hC2FF_0001;
        for (int i = 0; i < 3; i++) begin
            check(ret_ready == 0, "R9", "ready during stall", ret_ready, 1);
            @(negedge clk);
            check(upd_valid == 0, "R9", "candidate during stall", upd_valid, 0);
            check(mem_wvalid == 1 && mem_waddr == held_a && mem_wdata == held_d,
                  "R8", "held write changed", mem_waddr, held_a);
        end
        mem_wready = 1'b1;
        finish_append(32'hC2FF_0001, 1'b0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9", "entries after stall", exp_q.size(), 0);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 60; i++) append(32'hE000_0000 + i, (i % 3) == 0);
        while (n_app % EPL != 0) append(32'hE100_0000 + n_app, 1'b0);
        repeat (3) @(negedge clk);
        check(n_lines == n_app / EPL, "R6", "line count after wrap", n_lines, n_app / EPL);
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_ignore();
        t_endmark();
        t_backpressure();
        t_wrap();
        report();
    end
endmodule